// File: doc/BRIEF.md
# CORDIC Phase-Keyed Symbol Generator

This block turns a serial data stream into quadrature carrier samples for four-phase keying. Incoming bits are grouped in pairs. The first bit of each pair steers the in-phase sign and the second bit steers the quadrature sign. Each completed pair selects one of four diagonal phase offsets. That offset is added to a running carrier phase.

A pipelined rotation-mode CORDIC turns the resulting angle into one cosine sample and one sine sample. The CORDIC starts from a vector lying on the real axis. The output level comes from the seed loaded into the x register. That seed is the wanted magnitude multiplied by the CORDIC gain-compensation factor (about 0.60725), so no multiplier follows the rotator. An upstream source pushes bits with a valid/ready handshake. One sample pair leaves the block for each symbol, marked by a one-cycle valid strobe.

Top module: `psk_cordic_gen`

## Requirements
- R1: Bits are accepted on a clock edge where `in_valid` and `in_ready` are both high. The first accepted bit of a pair is the I bit and the second is the Q bit. Each second bit completes exactly one symbol.
- R2: The symbol offset depends on the (I,Q) pair, in angle units where 65536 is one turn: (0,0)→8192 (45°), (1,0)→24576 (135°), (1,1)→40960 (225°), (0,1)→57344 (315°).
- R3: The angle of a symbol is its offset plus the carrier phase, taken modulo 65536. The carrier phase starts at 0 after reset. `phase_step` is sampled with the Q bit and added to the carrier phase after that symbol's angle is formed. Between symbols the carrier phase does not change.
- R4: `out_i` approximates A·cos(θ)·32768 and `out_q` approximates A·sin(θ)·32768, each within ±12 LSB, where θ is the symbol angle.
- R5: `amp_sel` is sampled with the Q bit and selects A: 0→1.0, 1→1/√2, 2→1/√3, 3→1/2.
- R6: Results outside the 16-bit signed range clamp to 32767 or −32768 and never wrap. For example, A=1 at θ=0 gives `out_i` = 32767.
- R7: `out_valid` is a one-cycle pulse that rises 17 clock edges after the edge accepting the Q bit. There is exactly one pulse per symbol, and symbols may be completed back to back.
- R8: While `rst_n` is low, `in_ready` is low. Reset discards any pending I bit and clears the carrier phase. `in_ready` is high from the first edge after reset.
- R9: With `in_valid` low the pairing state does not change. `out_valid` pulses only for completed symbols.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Serial bit present |
| in_bit | input | 1 | Serial data bit |
| in_ready | output | 1 | Block can accept a bit |
| phase_step | input | 16 | Carrier phase increment per symbol, 65536 per turn |
| amp_sel | input | 2 | Output magnitude selection |
| out_valid | output | 1 | Sample pair strobe |
| out_i | output | 16 | In-phase sample, signed, 2^15 = 1.0 |
| out_q | output | 16 | Quadrature sample, signed, 2^15 = 1.0 |

## Verification
The bench builds the block with its default 16 iterations. At that depth the full angle accuracy and the full saturation behaviour are visible at the outputs.

It sweeps every symbol against every magnitude setting under several phase-step values, including 0, a quarter turn and minus an eighth of a turn. This puts the four quadrant folds and the exact θ=0 full-scale clamp within reach. Stalls inside a pair and a reset between the two bits of a pair test the pairing and clearing rules. Arrival cycles are compared against the fixed pipeline depth.

// File: rtl/psk_cordic_pkg.sv
package psk_cordic_pkg;
  localparam int DW    = 16;  // sample width
  localparam int AW    = 16;  // angle width, 2^AW per turn
  localparam int GUARD = 2;   // extra fraction bits inside rotator

  // arctan(2^-i) in angle units of 2^AW per turn
  function automatic logic [AW-1:0] atan_unit(input int i);
    case (i)
      0:  return 16'd8192;
      1:  return 16'd4836;
      2:  return 16'd2555;
      3:  return 16'd1297;
      4:  return 16'd651;
      5:  return 16'd326;
      6:  return 16'd163;
      7:  return 16'd81;
      8:  return 16'd41;
      9:  return 16'd20;
      10: return 16'd10;
      11: return 16'd5;
      12: return 16'd3;
      13: return 16'd1;
      14: return 16'd1;
      default: return 16'd0;
    endcase
  endfunction

  // diagonal offset picked by the (I,Q) pair
  function automatic logic [AW-1:0] quad_offset(input logic ib, input logic qb);
    case ({ib, qb})
      2'b00:   return 16'd8192;
      2'b10:   return 16'd24576;
      2'b11:   return 16'd40960;
      default: return 16'd57344;
    endcase
  endfunction

  // x seed = gain compensation * magnitude * 2^15
  function automatic logic [DW-1:0] amp_seed(input logic [1:0] sel);
    case (sel)
      2'd0:    return 16'd19899;  // 1.0
      2'd1:    return 16'd14071;  // 1/sqrt(2)
      2'd2:    return 16'd11489;  // 1/sqrt(3)
      default: return 16'd9949;   // 1/2
    endcase
  endfunction
endpackage

// File: rtl/psk_symbol_front.sv
module psk_symbol_front
  import psk_cordic_pkg::*;
#(
  parameter int IW = DW + GUARD + 2,
  parameter int ZW = AW + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_bit,
  input  logic [AW-1:0]        phase_step,
  input  logic [1:0]           amp_sel,
  output logic                 in_ready,
  output logic                 sym_fire,
  output logic                 half_full,
  output logic [AW-1:0]        acc,
  output logic                 v0,
  output logic signed [IW-1:0] x0,
  output logic signed [IW-1:0] y0,
  output logic signed [ZW-1:0] z0
);
  logic          even_bit;
  logic          take;
  logic [AW-1:0] theta;
  logic [AW-1:0] folded;
  logic          flip;
  logic signed [IW-1:0] seed_ext;

  assign take     = in_valid && in_ready;
  assign sym_fire = take && half_full;
  assign theta    = acc + quad_offset(even_bit, in_bit);
  assign flip     = theta[AW-1] ^ theta[AW-2];
  assign folded   = flip ? (theta ^ {1'b1, {(AW-1){1'b0}}}) : theta;
  assign seed_ext = $signed({{(IW-DW-GUARD){1'b0}}, amp_seed(amp_sel), {GUARD{1'b0}}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_ready  <= 1'b0;
      half_full <= 1'b0;
      even_bit  <= 1'b0;
      acc       <= '0;
      v0        <= 1'b0;
      x0        <= '0;
      y0        <= '0;
      z0        <= '0;
    end else begin
      in_ready <= 1'b1;
      v0       <= sym_fire;
      if (take) begin
        if (!half_full) begin
          even_bit  <= in_bit;
          half_full <= 1'b1;
        end else begin
          half_full <= 1'b0;
          acc       <= acc + phase_step;
          x0        <= flip ? -seed_ext : seed_ext;
          y0        <= '0;
          z0        <= $signed({{(ZW-AW){folded[AW-1]}}, folded});
        end
      end
    end
  end
endmodule

// File: rtl/psk_cordic_stage.sv
module psk_cordic_stage
  import psk_cordic_pkg::*;
#(
  parameter int IDX = 0,
  parameter int IW  = DW + GUARD + 2,
  parameter int ZW  = AW + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 v_i,
  input  logic signed [IW-1:0] x_i,
  input  logic signed [IW-1:0] y_i,
  input  logic signed [ZW-1:0] z_i,
  output logic                 v_o,
  output logic signed [IW-1:0] x_o,
  output logic signed [IW-1:0] y_o,
  output logic signed [ZW-1:0] z_o
);
  logic signed [IW-1:0] xs, ys;
  logic signed [ZW-1:0] step_ang;

  assign xs       = x_i >>> IDX;
  assign ys       = y_i >>> IDX;
  assign step_ang = $signed({{(ZW-AW){1'b0}}, atan_unit(IDX)});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_o <= 1'b0;
      x_o <= '0;
      y_o <= '0;
      z_o <= '0;
    end else begin
      v_o <= v_i;
      if (!z_i[ZW-1]) begin
        x_o <= x_i - ys;
        y_o <= y_i + xs;
        z_o <= z_i - step_ang;
      end else begin
        x_o <= x_i + ys;
        y_o <= y_i - xs;
        z_o <= z_i + step_ang;
      end
    end
  end
endmodule

// File: rtl/psk_sat_out.sv
module psk_sat_out
  import psk_cordic_pkg::*;
#(
  parameter int IW = DW + GUARD + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 v_i,
  input  logic signed [IW-1:0] x_i,
  input  logic signed [IW-1:0] y_i,
  output logic                 v_o,
  output logic signed [DW-1:0] i_o,
  output logic signed [DW-1:0] q_o
);
  localparam logic signed [IW-1:0] HI  = $signed({{(IW-DW+1){1'b0}}, {(DW-1){1'b1}}});
  localparam logic signed [IW-1:0] LO  = $signed({{(IW-DW+1){1'b1}}, {(DW-1){1'b0}}});
  localparam logic signed [IW-1:0] RND = $signed({{(IW-GUARD){1'b0}}, 1'b1, {(GUARD-1){1'b0}}});

  // round away guard bits, then clamp into the sample range
  function automatic logic signed [DW-1:0] round_clamp(input logic signed [IW-1:0] v);
    logic signed [IW-1:0] r;
    r = (v + RND) >>> GUARD;
    if (r > HI)      return HI[DW-1:0];
    else if (r < LO) return LO[DW-1:0];
    else             return r[DW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_o <= 1'b0;
      i_o <= '0;
      q_o <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) begin
        i_o <= round_clamp(x_i);
        q_o <= round_clamp(y_i);
      end
    end
  end
endmodule

// File: rtl/psk_cordic_gen.sv
module psk_cordic_gen
  import psk_cordic_pkg::*;
#(
  parameter int ITER = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_bit,
  output logic                 in_ready,
  input  logic [15:0]          phase_step,
  input  logic [1:0]           amp_sel,
  output logic                 out_valid,
  output logic signed [15:0]   out_i,
  output logic signed [15:0]   out_q
);
  localparam int IW = DW + GUARD + 2;
  localparam int ZW = AW + 2;

  logic                 sym_fire;
  logic                 half_full;
  logic [AW-1:0]        acc;
  logic                 vs [0:ITER];
  logic signed [IW-1:0] xs [0:ITER];
  logic signed [IW-1:0] ys [0:ITER];
  logic signed [ZW-1:0] zs [0:ITER];

  psk_symbol_front #(.IW(IW), .ZW(ZW)) u_front (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .phase_step(phase_step), .amp_sel(amp_sel), .in_ready(in_ready),
    .sym_fire(sym_fire), .half_full(half_full), .acc(acc),
    .v0(vs[0]), .x0(xs[0]), .y0(ys[0]), .z0(zs[0])
  );

  for (genvar g = 0; g < ITER; g++) begin : g_stage
    psk_cordic_stage #(.IDX(g), .IW(IW), .ZW(ZW)) u_stage (
      .clk(clk), .rst_n(rst_n),
      .v_i(vs[g]), .x_i(xs[g]), .y_i(ys[g]), .z_i(zs[g]),
      .v_o(vs[g+1]), .x_o(xs[g+1]), .y_o(ys[g+1]), .z_o(zs[g+1])
    );
  end

  psk_sat_out #(.IW(IW)) u_out (
    .clk(clk), .rst_n(rst_n), .v_i(vs[ITER]), .x_i(xs[ITER]), .y_i(ys[ITER]),
    .v_o(out_valid), .i_o(out_i), .q_o(out_q)
  );
endmodule

// File: rtl/psk_cordic_gen_chk.sv
module psk_cordic_gen_chk #(
  parameter int LAT = 18
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        sym_fire,
  input logic        half_full,
  input logic [15:0] acc,
  input logic        out_valid
);
  logic [7:0] inflight;

  always_ff @(posedge clk) begin
    if (!rst_n) inflight <= '0;
    else        inflight <= inflight + {7'd0, sym_fire} - {7'd0, out_valid};
  end

  // R1
  pair_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_fire |=> !half_full);

  // R9
  pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(half_full));

  // R3
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_fire |=> $stable(acc));

  // R7
  inflight_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= 8'(LAT));

  // R9
  no_orphan_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> inflight != 8'd0);
endmodule

bind psk_cordic_gen psk_cordic_gen_chk #(.LAT(ITER + 2)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sym_fire(sym_fire),
  .half_full(half_full), .acc(acc), .out_valid(out_valid)
);

// File: tb/psk_cordic_gen_bench.sv
module psk_cordic_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic in_ready;
  logic [15:0] phase_step = '0;
  logic [1:0] amp_sel = '0;
  logic out_valid;
  logic signed [15:0] out_i, out_q;

  always #2 clk = ~clk;  // 250 MHz

  psk_cordic_gen u_psk_cordic_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .in_ready(in_ready), .phase_step(phase_step), .amp_sel(amp_sel),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // bench model state
  bit pend = 0;
  bit ev = 0;
  int acc_m = 0;
  int exp_i [0:511];
  int exp_q [0:511];
  int exp_due [0:511];
  int head = 0;
  int tail = 0;

  function automatic int rnd(input real r);
    return (r >= 0.0) ? $rtoi(r + 0.5) : $rtoi(r - 0.5);
  endfunction
  function automatic int clampv(input int v);
    return (v > 32767) ? 32767 : ((v < -32768) ? -32768 : v);
  endfunction
  function automatic real amp_of(input int s);
    case (s)
      0: return 1.0;
      1: return 1.0 / $sqrt(2.0);
      2: return 1.0 / $sqrt(3.0);
      default: return 0.5;
    endcase
  endfunction
  function automatic int offset_of(input bit ib, input bit qb);
    // R2 mapping
    if (!ib && !qb) return 1;
    if (ib && !qb)  return 3;
    if (ib && qb)   return 5;
    return 7;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // send one bit this cycle; model updated predictively
  task automatic send_bit(input bit b, input int sel, input int step);
    real th, a;
    int ang;
    @(negedge clk);
    check(in_ready == 1'b1, "R8 ready", int'(in_ready), 1);
    in_valid = 1'b1;
    in_bit = b;
    amp_sel = 2'(sel);
    phase_step = 16'(step);
    if (!pend) begin
      pend = 1; ev = b;
    end else begin
      pend = 0;
      ang = (acc_m + offset_of(ev, b) * 8192) % 65536;
      acc_m = (acc_m + step) % 65536;
      th = 2.0 * 3.14159265358979 * real'(ang) / 65536.0;
      a = amp_of(sel) * 32768.0;
      exp_i[tail % 512] = clampv(rnd(a * $cos(th)));
      exp_q[tail % 512] = clampv(rnd(a * $sin(th)));
      exp_due[tail % 512] = cyc + 18;
      tail++;
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_bit = ~in_bit;
    end
  endtask

  task automatic send_sym(input bit ib, input bit qb, input int sel, input int step);
    send_bit(ib, 0, 0);
    send_bit(qb, sel, step);
  endtask

  // output monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (head == tail) begin
        check(1'b0, "R9 unexpected out_valid", 1, 0);
      end else begin
        int ei, eq;
        ei = exp_i[head % 512];
        eq = exp_q[head % 512];
        check(cyc == exp_due[head % 512], "R7 latency", cyc, exp_due[head % 512]);
        if (ei == 32767 || ei == -32768)
          check(int'(out_i) == ei, "R6 I clamp", int'(out_i), ei);
        else
          check(int'(out_i) - ei <= 12 && ei - int'(out_i) <= 12, "R4/R5 I sample", int'(out_i), ei);
        if (eq == 32767 || eq == -32768)
          check(int'(out_q) == eq, "R6 Q clamp", int'(out_q), eq);
        else
          check(int'(out_q) - eq <= 12 && eq - int'(out_q) <= 12, "R4/R5 Q sample", int'(out_q), eq);
        head++;
      end
    end
  end

  // watchdog
  always @(negedge clk) begin
    if (!done && cyc > 50000) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  int steps [0:4] = '{0, 1000, 16384, 57344, 12345};

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    check(in_ready == 1'b0, "R8 ready in reset", int'(in_ready), 0);
    check(out_valid == 1'b0, "R8 valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R8 valid after reset", int'(out_valid), 0);

    // R6: A=1 at theta 0 -> 32767 on I
    send_sym(0, 0, 0, 57344);   // 45 deg, carrier -> -45
    send_sym(0, 0, 0, 0);       // 0 deg
    idle(2);

    // R1 R2 R3 R5: sweep symbols, magnitudes, steps, back to back
    for (int s = 0; s < 5; s++)
      for (int m = 0; m < 4; m++)
        for (int b = 0; b < 4; b++)
          send_sym(b[1], b[0], m, steps[s]);
    idle(3);

    // R9: stalls inside a pair
    send_bit(1, 0, 0); idle(4); send_bit(0, 2, 4000);
    send_bit(0, 0, 0); idle(1); send_bit(1, 1, 300);
    idle(25);
    check(head == tail, "R9 no pending samples", head, tail);

    // R8: reset drops a pending I bit and clears carrier phase
    send_bit(1, 0, 0);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    pend = 0;
    acc_m = 0;
    @(negedge clk);
    check(in_ready == 1'b0, "R8 ready low in reset", int'(in_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    send_sym(0, 1, 3, 100);     // expect 315 deg at A=1/2 from zero phase
    send_sym(1, 1, 0, 0);
    idle(25);

    // R7: all outputs arrived, each once
    check(head == tail, "R7 every symbol produced one sample", head, tail);
    check(out_valid == 1'b0, "R9 idle output", int'(out_valid), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule